// File: doc/BRIEF.md
# Streaming Sample Histogram Accumulator

This block counts how often each sample value occurs in a stream that delivers one sample per clock. Each sample addresses one bin of an internal count memory. The block reads that bin, adds one and writes the result back. The memory has a two-cycle read path, so the update runs as a three-stage pipeline. Updates to a bin that is still in flight are forwarded, so no count is lost.

A restart pulse latches a window length and opens a collection window for exactly that many samples. When the window closes, the block reports completion. An internal address ramp makes one pass over every bin. When the clear input is high, the pass zeroes every bin. When the clear input is low, the pass streams the bins out in ascending order, each with a valid strobe and its address. Sample updates are held off for as long as the sweep-select input is high. The whole block runs on one clock. The bin count is set by the address width parameter: a width of 14 gives 16,384 bins, and the counts are 16 bits wide.

Top module: `hist_accum`

## Requirements
- R1: During a collection window, each accepted sample increments the bin whose index equals the sample value by exactly one.
- R2: After a restart pulse, sampled with sweep-select low, the block accepts exactly `sampleLimit` samples, one per clock, starting in the cycle after the pulse. Samples presented after the window has closed leave every bin unchanged.
- R3: Repeated hits on one bin in consecutive or near-consecutive cycles are all counted. This holds even while an earlier update to that bin has not yet reached memory.
- R4: A bin count saturates at its all-ones value and never wraps to zero.
- R5: With sweep-select and clear both high, one ramp pass writes zero to every bin and raises no `rdValid`.
- R6: With sweep-select high and clear low, the bins are delivered one per clock in ascending address order. Each delivery has `rdValid` high, `rdAddr` set to the bin index and `rdCount` set to its count.
- R7: The ramp makes a single pass. `sweepDone` goes high when the last bin is retired, stays high with no further `rdValid` while sweep-select is high, and returns low once sweep-select goes low, which rearms the ramp at bin 0.
- R8: While sweep-select is high, samples are not counted and restart pulses are ignored. An open window pauses and resumes, with its progress kept, when sweep-select falls.
- R9: `busy` is high from the cycle after a restart until the last sample of the window is accepted. `done` is high after that until the next restart. A window length of zero sets `done` at once.
- R10: After reset, `busy`, `done`, `rdValid` and `sweepDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rstN | input | 1 | Asynchronous active-low reset |
| sample | input | ADDR_W | Incoming sample, which is also the bin index |
| start | input | 1 | Restart pulse that opens a new collection window |
| sampleLimit | input | LEN_W | Window length in samples, latched on restart |
| sweepSel | input | 1 | Selects the internal ramp as the bin address and runs a sweep |
| clearSel | input | 1 | When high during a sweep, writes zero instead of reading out |
| busy | output | 1 | Collection window open |
| done | output | 1 | Window completed |
| rdValid | output | 1 | Readout count valid this cycle |
| rdAddr | output | ADDR_W | Bin index of the readout count |
| rdCount | output | COUNT_W | Readout count |
| sweepDone | output | 1 | Ramp pass finished |

## Verification
The bench aims at back-to-back and every-other-cycle hits on a single bin. Without forwarding from both later pipeline stages, such a stream would lose counts, and the readout would show one or two instead of the full total. Heavy repetition of one bin checks saturation, where a wrapping increment would read back near zero. A sweep raised in the middle of a window, together with a restart pulse and junk samples, must leave the window paused and intact. A design that leaked samples or honoured the restart would show extra counts or a shifted completion. Zero-length windows, an exact window boundary followed by surplus samples, and the end and rearm of a single ramp pass complete the set.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_INC  = 2'd1,
    OP_CLR  = 2'd2,
    OP_RD   = 2'd3
  } opKind_t;

  typedef struct packed {
    opKind_t kind;   // what the datapath does with this address
    logic    last;   // final ramp step
    logic    rearm;  // sweep select is low: drop sweep completion
  } ctrlStrobe_t;
endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sample,
  input  logic              start,
  input  logic [LEN_W-1:0]  sampleLimit,
  input  logic              sweepSel,
  input  logic              clearSel,
  output logic [ADDR_W-1:0] opAddr,
  output ctrlStrobe_t       strobe,
  output logic              busy,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_BIN = '1;

  logic [LEN_W-1:0]  sampleCnt;
  logic [LEN_W-1:0]  limitReg;
  logic              collecting;
  logic              doneFlag;
  logic [ADDR_W-1:0] rampAddr;
  logic              rampFinished;

  // collection window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt  <= '0;
      limitReg   <= '0;
      collecting <= 1'b0;
      doneFlag   <= 1'b0;
    end else if (!sweepSel) begin
      if (start) begin
        sampleCnt  <= '0;
        limitReg   <= sampleLimit;
        collecting <= (sampleLimit != '0);
        doneFlag   <= (sampleLimit == '0);
      end else if (collecting) begin
        sampleCnt <= sampleCnt + LEN_W'(1);
        if (sampleCnt == limitReg - LEN_W'(1)) begin
          collecting <= 1'b0;
          doneFlag   <= 1'b1;
        end
      end
    end
  end

  // address ramp, one pass per sweep
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampAddr     <= '0;
      rampFinished <= 1'b0;
    end else if (!sweepSel) begin
      rampAddr     <= '0;
      rampFinished <= 1'b0;
    end else if (!rampFinished) begin
      rampAddr <= rampAddr + ADDR_W'(1);
      if (rampAddr == LAST_BIN) rampFinished <= 1'b1;
    end
  end

  always_comb begin
    strobe.kind  = OP_NONE;
    strobe.last  = 1'b0;
    strobe.rearm = !sweepSel;
    opAddr       = sample;
    if (sweepSel) begin
      opAddr = rampAddr;
      if (!rampFinished) begin
        strobe.kind = clearSel ? OP_CLR : OP_RD;
        strobe.last = (rampAddr == LAST_BIN);
      end
    end else if (collecting && !start) begin
      strobe.kind = OP_INC;
    end
  end

  assign busy = collecting;
  assign done = doneFlag;

  assert_exclusive_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    collecting |-> (sampleCnt < limitReg));
  assert_no_update_in_sweep_R8: assert property (@(posedge clk) disable iff (!rstN)
    sweepSel |-> (strobe.kind != OP_INC));
  assert_pause_keeps_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    sweepSel |=> $stable(sampleCnt));
endmodule

// File: rtl/hist_datapath.sv
module hist_datapath
  import hist_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  opAddr,
  input  ctrlStrobe_t        strobe,
  output logic               rdValid,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [COUNT_W-1:0] rdCount,
  output logic               sweepDone
);
  localparam int BINS = 1 << ADDR_W;

  logic [COUNT_W-1:0] binMem [BINS];

  opKind_t            s1Kind, s2Kind;
  logic [ADDR_W-1:0]  s1Addr, s2Addr;
  logic               s1Last, s2Last;
  logic [COUNT_W-1:0] rdStage1, rdStage2;

  // the last two writes to memory, newest first
  logic               wrV1, wrV2;
  logic [ADDR_W-1:0]  wrA1, wrA2;
  logic [COUNT_W-1:0] wrD1, wrD2;

  logic [COUNT_W-1:0] oldVal, incVal, wrData;
  logic               wrEn;

  always_comb begin
    if (wrV1 && wrA1 == s2Addr)      oldVal = wrD1;
    else if (wrV2 && wrA2 == s2Addr) oldVal = wrD2;
    else                             oldVal = rdStage2;
    incVal = (oldVal == '1) ? oldVal : oldVal + COUNT_W'(1);
    wrEn   = (s2Kind == OP_INC) || (s2Kind == OP_CLR);
    wrData = (s2Kind == OP_CLR) ? '0 : incVal;
  end

  // bin memory: two-cycle registered read, read before write
  always_ff @(posedge clk) begin
    if (wrEn) binMem[s2Addr] <= wrData;
    rdStage1 <= binMem[opAddr];
    rdStage2 <= rdStage1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Kind    <= OP_NONE;
      s2Kind    <= OP_NONE;
      s1Addr    <= '0;
      s2Addr    <= '0;
      s1Last    <= 1'b0;
      s2Last    <= 1'b0;
      wrV1      <= 1'b0;
      wrV2      <= 1'b0;
      wrA1      <= '0;
      wrA2      <= '0;
      wrD1      <= '0;
      wrD2      <= '0;
      rdValid   <= 1'b0;
      rdAddr    <= '0;
      rdCount   <= '0;
      sweepDone <= 1'b0;
    end else begin
      s1Kind <= strobe.kind;
      s1Addr <= opAddr;
      s1Last <= strobe.last;
      s2Kind <= s1Kind;
      s2Addr <= s1Addr;
      s2Last <= s1Last;
      wrV1   <= wrEn;
      wrA1   <= s2Addr;
      wrD1   <= wrData;
      wrV2   <= wrV1;
      wrA2   <= wrA1;
      wrD2   <= wrD1;
      rdValid <= (s2Kind == OP_RD);
      if (s2Kind == OP_RD) begin
        rdAddr  <= s2Addr;
        rdCount <= oldVal;
      end
      if (strobe.rearm)
        sweepDone <= 1'b0;
      else if (s2Last && s2Kind != OP_NONE)
        sweepDone <= 1'b1;
    end
  end

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (s2Kind == OP_INC) |-> (wrData != '0));
  assert_ascending_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdValid)) |-> (rdAddr == $past(rdAddr) + ADDR_W'(1)));
  assert_single_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sweepDone && $past(sweepDone)) |-> !rdValid);
  assert_forward_monotone_R3: assert property (@(posedge clk) disable iff (!rstN)
    (s2Kind == OP_INC) |-> (wrData >= oldVal));
endmodule

// File: rtl/hist_accum.sv
module hist_accum
  import hist_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int COUNT_W = 16,
  parameter int LEN_W   = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  sample,
  input  logic               start,
  input  logic [LEN_W-1:0]   sampleLimit,
  input  logic               sweepSel,
  input  logic               clearSel,
  output logic               busy,
  output logic               done,
  output logic               rdValid,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [COUNT_W-1:0] rdCount,
  output logic               sweepDone
);
  logic [ADDR_W-1:0] opAddr;
  ctrlStrobe_t       strobe;

  hist_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sample(sample), .start(start),
    .sampleLimit(sampleLimit), .sweepSel(sweepSel), .clearSel(clearSel),
    .opAddr(opAddr), .strobe(strobe), .busy(busy), .done(done)
  );

  hist_datapath #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) uPath (
    .clk(clk), .rstN(rstN), .opAddr(opAddr), .strobe(strobe),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdCount(rdCount),
    .sweepDone(sweepDone)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |=> !(busy || done || rdValid || sweepDone));
endmodule

// File: tb/tb_hist_accum.sv
module tb_hist_accum;
  localparam int ADDR_W  = 5;
  localparam int COUNT_W = 4;
  localparam int LEN_W   = 8;
  localparam int BINS    = 1 << ADDR_W;
  localparam int MAXC    = (1 << COUNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] sample = '0;
  logic start = 1'b0;
  logic [LEN_W-1:0] sampleLimit = '0;
  logic sweepSel = 1'b0;
  logic clearSel = 1'b0;
  logic busy, done, rdValid, sweepDone;
  logic [ADDR_W-1:0] rdAddr;
  logic [COUNT_W-1:0] rdCount;

  always #2.5 clk = ~clk;

  hist_accum #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .sample(sample), .start(start),
    .sampleLimit(sampleLimit), .sweepSel(sweepSel), .clearSel(clearSel),
    .busy(busy), .done(done), .rdValid(rdValid), .rdAddr(rdAddr),
    .rdCount(rdCount), .sweepDone(sweepDone)
  );

  typedef struct { int a; int c; } expItem_t;
  expItem_t expQ[$];
  int model[BINS];
  int checks = 0;
  int errors = 0;

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic int sampleOf(input int mode, input int i);
    case (mode)
      0: return (i * 7 + 3) % BINS;
      1: return 3;
      2: return (i % 2 == 0) ? 9 : 10;
      3: return (i % 3 == 1) ? 13 : 12;
      default: return 7;
    endcase
  endfunction

  // scoreboard monitor: R6 delivery order and contents
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checkEq("R6", "unexpected rdValid (queue empty)", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        checkEq("R6", "rdAddr", int'(rdAddr), e.a);
        checkEq("R6", $sformatf("rdCount bin %0d", e.a), int'(rdCount), e.c);
      end
    end
  end

  task automatic bump(input int b);
    if (model[b] < MAXC) model[b]++;
  endtask

  task automatic waitSweep(input string req);
    int guard = 0;
    while (!sweepDone && guard < 4 * BINS) begin
      tick;
      guard++;
    end
    checkEq(req, "sweepDone reached", int'(sweepDone), 1);
  endtask

  task automatic clearAll;
    sweepSel = 1'b1;
    clearSel = 1'b1;
    waitSweep("R5");
    sweepSel = 1'b0;
    clearSel = 1'b0;
    for (int b = 0; b < BINS; b++) model[b] = 0;
    tick;
  endtask

  task automatic readout(input string req);
    for (int b = 0; b < BINS; b++) expQ.push_back('{b, model[b]});
    sweepSel = 1'b1;
    clearSel = 1'b0;
    waitSweep("R7");
    repeat (3) tick;
    checkEq(req, "readout items left", expQ.size(), 0);
    checkEq("R7", "sweepDone held", int'(sweepDone), 1);
    sweepSel = 1'b0;
    tick;
    checkEq("R7", "sweepDone rearm", int'(sweepDone), 0);
  endtask

  task automatic collect(input int limit, input int n, input int mode, input string req);
    sampleLimit = LEN_W'(limit);
    start = 1'b1;
    tick;
    start = 1'b0;
    checkEq("R9", "busy after restart", int'(busy), int'(limit != 0));
    for (int i = 0; i < n; i++) begin
      sample = ADDR_W'(sampleOf(mode, i));
      if (i < limit) bump(sampleOf(mode, i));
      tick;
      if (i == limit - 1) begin
        checkEq("R9", "done at window end", int'(done), 1);
        checkEq("R2", "busy off at window end", int'(busy), 0);
      end
    end
    repeat (4) tick;
    checkEq(req, "done after collection", int'(done), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick;
    checkEq("R10", "busy in reset", int'(busy), 0);
    checkEq("R10", "done in reset", int'(done), 0);
    checkEq("R10", "rdValid in reset", int'(rdValid), 0);
    checkEq("R10", "sweepDone in reset", int'(sweepDone), 0);
    rstN = 1'b1;
    tick;

    clearAll;
    readout("R5");

    // R1/R2: spread pattern with surplus samples after the window
    collect(20, 26, 0, "R1");
    readout("R2");

    // R3: forwarding patterns
    collect(10, 10, 1, "R3");
    collect(9, 9, 2, "R3");
    collect(9, 9, 3, "R3");
    readout("R3");

    // R9: zero-length window
    sampleLimit = '0;
    start = 1'b1;
    tick;
    start = 1'b0;
    checkEq("R9", "zero window done", int'(done), 1);
    checkEq("R9", "zero window busy", int'(busy), 0);
    for (int i = 0; i < 5; i++) begin
      sample = ADDR_W'(20);
      tick;
    end
    readout("R2");

    // R4: saturation
    collect(20, 20, 4, "R4");
    readout("R4");

    // R8: sweep in the middle of a window
    sampleLimit = LEN_W'(12);
    start = 1'b1;
    tick;
    start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      sample = ADDR_W'(1);
      bump(1);
      tick;
    end
    for (int b = 0; b < BINS; b++) expQ.push_back('{b, model[b]});
    sweepSel = 1'b1;
    start = 1'b1;
    sampleLimit = LEN_W'(3);
    sample = ADDR_W'(31);
    tick;
    start = 1'b0;
    waitSweep("R8");
    repeat (3) tick;
    checkEq("R8", "readout during pause", expQ.size(), 0);
    checkEq("R8", "window still open", int'(busy), 1);
    sweepSel = 1'b0;
    sampleLimit = LEN_W'(12);
    for (int i = 0; i < 7; i++) begin
      sample = ADDR_W'(2);
      bump(2);
      tick;
    end
    checkEq("R8", "window resumed and closed", int'(done), 1);
    repeat (4) tick;
    readout("R8");

    clearAll;
    readout("R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule